// File: doc/BRIEF.md
# Serial SRAM Word Access Master

This block lets a processor core read or write one 16-bit word in an external serial SRAM over a four-wire SPI link. The core raises a request carrying the direction (read or write), a flag that marks a read as an instruction fetch, a 16-bit address and, for writes, a 16-bit word. The block then runs one complete chip-select frame. The frame holds an 8-bit command, the address and 16 data bits, 40 bits in total, sent most significant bit first. The serial clock runs at half the system clock.

The outgoing frame is held in a register. A bit counter selects one frame bit at a time through a 40-way one-hot selector. During a read, the incoming bits are steered into one of two result registers: the instruction word for a fetch, or the data word for any other read. A small sequencer, separate from the core's own control, orders the frame. Its states are IDLE, LEAD, HIGH, LOW, TAIL and DONE. Its transitions are as follows. IDLE goes to LEAD when a request arrives. LEAD goes to HIGH. HIGH goes to LOW while bits remain, and to TAIL after the last bit. LOW goes to HIGH. TAIL goes to DONE. DONE goes to IDLE.

Top module: `spi_word_master`

## Requirements
- R1: While reset is held and after its release, the outputs are csb=1, sclk=0, mosi=0, done=0, busy=0, and both result words are 0.
- R2: The 40 frame bits appear on mosi MSB first. Bits 0–7 are the command: 0x03 for a read and 0x02 for a write. Bits 8–23 are the address. Bits 24–39 are the write data for a write, and are driven 0 for a read.
- R3: mosi changes only while sclk is low, and it is stable across every rising sclk edge.
- R4: sclk is low whenever csb is high. Each high and each low phase of sclk lasts one system clock. A frame has exactly 40 rising edges.
- R5: csb goes low in the cycle after the request is accepted. That is one system clock before the first rising edge of sclk. csb stays low for one system clock after the last sclk high phase, and then returns high.
- R6: On a read, the miso values seen at rising edges 25 to 40 are shifted MSB first into instr_word when the read is a fetch, and into data_word otherwise. The other word is left unchanged.
- R7: A write leaves both result words unchanged, and neither word changes while csb is high.
- R8: done is high for exactly one cycle: the first cycle in which csb is high again. This is 82 cycles after the clock edge that accepts the request.
- R9: busy is high from the cycle after acceptance through the done cycle. A request is accepted only while busy is low, and a request raised while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | For a read: 1 = instruction fetch |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| instr_word | output | 16 | Last fetched instruction |
| data_word | output | 16 | Last read data word |
| csb | output | 1 | SRAM chip select, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the SRAM |
| miso | input | 1 | Serial data from the SRAM |

## Verification
The bench counts cycles from the clock edge that accepts a request, numbering them t = 1 onward. csb is low for t = 1..81, and sclk is high on the even values of t from 2 to 80. mosi carries bit 0 at t = 1, and then the next bit after each falling edge. Each result bit is due one cycle after the high phase that samples it, and done is due at t = 82. The behavioural model advances t on every rising clock edge, and every output is compared against it on the falling edge. A bench-side SRAM model also decodes the whole frame and counts sclk edges whenever csb rises.

// File: rtl/spi_word_pkg.sv
package spi_word_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TAIL,
        ST_DONE
    } seq_state_e;

    localparam logic [7:0] CMD_READ  = 8'h03;
    localparam logic [7:0] CMD_WRITE = 8'h02;

endpackage

// File: rtl/spi_frame_builder.sv
module spi_frame_builder
    import spi_word_pkg::*;
#(
    parameter int CMD_W  = 8,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    localparam int FRAME_W = CMD_W + ADDR_W + DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               is_write,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [FRAME_W-1:0] frame
);

    logic [CMD_W-1:0]  cmd_field;
    logic [DATA_W-1:0] data_field;

    always_comb begin
        cmd_field  = is_write ? CMD_W'(CMD_WRITE) : CMD_W'(CMD_READ);
        data_field = is_write ? wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame <= '0;
        end else if (load) begin
            frame <= {cmd_field, addr, data_field};
        end
    end

endmodule

// File: rtl/spi_bit_select.sv
module spi_bit_select #(
    parameter int FRAME_W = 40,
    localparam int CNT_W  = $clog2(FRAME_W)
) (
    input  logic [FRAME_W-1:0] frame,
    input  logic [CNT_W-1:0]   idx,
    input  logic               enable,
    output logic               bit_out
);

    logic [FRAME_W-1:0] hit;

    for (genvar i = 0; i < FRAME_W; i++) begin : g_slot
        assign hit[i] = (idx == CNT_W'(i)) & frame[FRAME_W-1-i];
    end

    assign bit_out = enable & (|hit);

endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift #(
    parameter int DATA_W   = 16,
    parameter int NUM_DEST = 2,
    localparam int SEL_W   = (NUM_DEST > 1) ? $clog2(NUM_DEST) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            shift_en,
    input  logic [SEL_W-1:0]                dest,
    input  logic                            bit_in,
    output logic [NUM_DEST-1:0][DATA_W-1:0] words
);

    for (genvar g = 0; g < NUM_DEST; g++) begin : g_dest
        logic [DATA_W-1:0] word_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (shift_en && (dest == SEL_W'(g))) begin
                word_q <= {word_q[DATA_W-2:0], bit_in};
            end
        end

        assign words[g] = word_q;
    end

endmodule

// File: rtl/spi_seq_fsm.sv
module spi_seq_fsm
    import spi_word_pkg::*;
#(
    parameter int FRAME_W  = 40,
    parameter int RX_START = 24,
    localparam int CNT_W   = $clog2(FRAME_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             load,
    output logic             sclk,
    output logic             csb,
    output logic             tx_enable,
    output logic             capture_slot,
    output logic             done,
    output logic             busy,
    output logic [CNT_W-1:0] bit_idx
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] RX_FIRST = CNT_W'(RX_START);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_LEAD;
                    cnt_d   = '0;
                end
            end
            ST_LEAD: state_d = ST_HIGH;
            ST_HIGH: begin
                if (cnt_q == LAST_BIT) begin
                    state_d = ST_TAIL;
                end else begin
                    state_d = ST_LOW;
                    cnt_d   = cnt_q + 1'b1;
                end
            end
            ST_LOW:  state_d = ST_HIGH;
            ST_TAIL: state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load         = 1'b0;
        sclk         = 1'b0;
        csb          = 1'b1;
        tx_enable    = 1'b0;
        capture_slot = 1'b0;
        done         = 1'b0;
        busy         = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                load = start;
            end
            ST_LEAD: begin
                csb       = 1'b0;
                tx_enable = 1'b1;
            end
            ST_HIGH: begin
                csb          = 1'b0;
                sclk         = 1'b1;
                tx_enable    = 1'b1;
                capture_slot = (cnt_q >= RX_FIRST);
            end
            ST_LOW: begin
                csb       = 1'b0;
                tx_enable = 1'b1;
            end
            ST_TAIL: csb  = 1'b0;
            ST_DONE: done = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    assign bit_idx = cnt_q;

endmodule

// File: rtl/spi_word_master.sv
module spi_word_master #(
    parameter int CMD_W  = 8,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_fetch,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] instr_word,
    output logic [DATA_W-1:0] data_word,
    output logic              csb,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso
);

    localparam int FRAME_W  = CMD_W + ADDR_W + DATA_W;
    localparam int CNT_W    = $clog2(FRAME_W);
    localparam int RX_START = CMD_W + ADDR_W;
    localparam int DEST_N   = 2;

    logic               load;
    logic               tx_enable;
    logic               capture_slot;
    logic [CNT_W-1:0]   bit_idx;
    logic [FRAME_W-1:0] frame;
    logic               write_q;
    logic               fetch_q;
    logic [DEST_N-1:0][DATA_W-1:0] words;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            write_q <= 1'b0;
            fetch_q <= 1'b0;
        end else if (load) begin
            write_q <= req_write;
            fetch_q <= req_fetch;
        end
    end

    spi_seq_fsm #(
        .FRAME_W  (FRAME_W),
        .RX_START (RX_START)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (req_valid),
        .load         (load),
        .sclk         (sclk),
        .csb          (csb),
        .tx_enable    (tx_enable),
        .capture_slot (capture_slot),
        .done         (done),
        .busy         (busy),
        .bit_idx      (bit_idx)
    );

    spi_frame_builder #(
        .CMD_W  (CMD_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .is_write (req_write),
        .addr     (req_addr),
        .wdata    (req_wdata),
        .frame    (frame)
    );

    spi_bit_select #(
        .FRAME_W (FRAME_W)
    ) u_select (
        .frame   (frame),
        .idx     (bit_idx),
        .enable  (tx_enable),
        .bit_out (mosi)
    );

    spi_rx_shift #(
        .DATA_W   (DATA_W),
        .NUM_DEST (DEST_N)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (capture_slot & ~write_q),
        .dest     (~fetch_q),
        .bit_in   (miso),
        .words    (words)
    );

    assign instr_word = words[0];
    assign data_word  = words[1];

endmodule

// File: rtl/spi_word_master_sva.sv
module spi_word_master_sva #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              csb,
    input logic              sclk,
    input logic              mosi,
    input logic              done,
    input logic              busy,
    input logic [DATA_W-1:0] instr_word,
    input logic [DATA_W-1:0] data_word
);

    p_csb_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> csb);

    p_sclk_parked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        csb |-> !sclk);

    p_sclk_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |=> $fell(sclk));

    p_mosi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(mosi));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (csb && !$past(csb)));

    p_done_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_words_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (csb && $past(csb)) |-> ($stable(instr_word) && $stable(data_word)));

endmodule

bind spi_word_master spi_word_master_sva #(.DATA_W(DATA_W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .csb        (csb),
    .sclk       (sclk),
    .mosi       (mosi),
    .done       (done),
    .busy       (busy),
    .instr_word (instr_word),
    .data_word  (data_word)
);

// File: tb/spi_word_master_bench.sv
module spi_word_master_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_fetch = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, csb, sclk, mosi;
    logic        miso = 1'b0;
    logic [15:0] instr_word, data_word;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    spi_word_master u_spi_word_master (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_fetch  (req_fetch),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .busy       (busy),
        .done       (done),
        .instr_word (instr_word),
        .data_word  (data_word),
        .csb        (csb),
        .sclk       (sclk),
        .mosi       (mosi),
        .miso       (miso)
    );

    function automatic logic [15:0] mem_word(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h5A3C;
    endfunction

    task automatic check(input string req, input string what, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at t=%0d", req, what, act, exp, cycles);
        end
    endtask

    // Behavioural reference model
    int          t = 0;
    logic        m_write, m_fetch;
    logic [15:0] m_addr;
    logic [39:0] exp_frame = '0;
    logic [15:0] exp_instr = '0;
    logic [15:0] exp_data = '0;

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            t = 0;
            exp_instr = '0;
            exp_data = '0;
        end else if (t == 0) begin
            if (req_valid) begin
                m_write = req_write;
                m_fetch = req_fetch;
                m_addr  = req_addr;
                exp_frame = {m_write ? 8'h02 : 8'h03, req_addr, m_write ? req_wdata : 16'h0000};
                t = 1;
            end
        end else begin
            if (!m_write && t >= 50 && t <= 80 && (t % 2) == 0) begin
                logic [15:0] w;
                int k;
                w = mem_word(m_addr);
                k = (t - 2) / 2;
                if (m_fetch) exp_instr = {exp_instr[14:0], w[15-(k-24)]};
                else         exp_data  = {exp_data[14:0],  w[15-(k-24)]};
            end
            t = (t == 82) ? 0 : t + 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            logic e_mosi;
            int idx;
            idx = -1;
            if (t == 1) idx = 0;
            else if (t >= 2 && t <= 80) idx = ((t % 2) == 0) ? (t - 2) / 2 : (t - 1) / 2;
            e_mosi = (idx >= 0) ? exp_frame[39-idx] : 1'b0;
            check("R5", "csb", 16'(csb), 16'(!(t >= 1 && t <= 81)));
            check("R4", "sclk", 16'(sclk), 16'(t >= 2 && t <= 80 && (t % 2) == 0));
            check("R2", "mosi", 16'(mosi), 16'(e_mosi));
            check("R8", "done", 16'(done), 16'(t == 82));
            check("R9", "busy", 16'(busy), 16'(t != 0));
            check("R6", "instr_word", instr_word, exp_instr);
            check("R6", "data_word", data_word, exp_data);
        end
    end

    // SRAM model on the serial side
    int          s_edges = 0;
    logic [39:0] s_shift = '0;
    logic        s_active = 1'b0;
    logic        s_read = 1'b0;
    logic [15:0] s_word = '0;

    always @(negedge csb) begin
        s_active = 1'b1;
        s_edges = 0;
        s_read = 1'b0;
    end

    always @(posedge sclk) begin
        s_shift = {s_shift[38:0], mosi};
        s_edges++;
        if (s_edges == 24) begin
            s_read = (s_shift[23:16] == 8'h03);
            s_word = mem_word(s_shift[15:0]);
        end
    end

    always @(negedge sclk) begin
        if (s_read && s_edges >= 24 && s_edges < 40) miso = s_word[39-s_edges];
        else miso = 1'b0;
    end

    always @(posedge csb) begin
        if (s_active && rst_n) begin
            s_active = 1'b0;
            check("R4", "rising edges", 16'(s_edges), 16'd40);
            check("R2", "frame hi", s_shift[39:24], exp_frame[39:24]);
            check("R2", "frame lo", s_shift[23:8], exp_frame[23:8]);
            check("R2", "frame tail", {8'h00, s_shift[7:0]}, {8'h00, exp_frame[7:0]});
        end
    end

    task automatic issue(input logic wr, input logic fe, input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_fetch = fe;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (85) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values while reset is held
        check("R1", "csb", 16'(csb), 16'd1);
        check("R1", "sclk", 16'(sclk), 16'd0);
        check("R1", "mosi", 16'(mosi), 16'd0);
        check("R1", "done", 16'(done), 16'd0);
        check("R1", "busy", 16'(busy), 16'd0);
        check("R1", "words", instr_word | data_word, 16'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        issue(1'b0, 1'b1, 16'h1234, 16'h0000);   // R6 fetch
        issue(1'b0, 1'b0, 16'hBEEF, 16'hFFFF);   // R6 data read, wdata ignored
        issue(1'b1, 1'b0, 16'h00FF, 16'hA5A5);   // R7 write
        issue(1'b1, 1'b1, 16'hFFFF, 16'hFFFF);   // R7 write, all ones
        issue(1'b0, 1'b1, 16'h0000, 16'h0000);   // R2 address boundary
        issue(1'b0, 1'b0, 16'hFFFF, 16'h0000);   // R2 address boundary

        // R9: a request raised mid-frame has no effect
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_fetch = 1'b0; req_addr = 16'h0F0F;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (20) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_fetch = 1'b1; req_addr = 16'h7777; req_wdata = 16'h1111;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (80) @(negedge clk);

        // R9: request held high gives back-to-back frames
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_fetch = 1'b1; req_addr = 16'h8001;
        repeat (170) @(negedge clk);
        req_valid = 1'b0;
        repeat (90) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule